// File: doc/BRIEF.md
# Host Controller Command Register

This block is the command word that software writes to steer a USB host controller, together with the busy flags that answer it. It holds four request bits: save state, restore state, full reset and light reset. Each request bit clears itself. When software sets one, the block raises a one-cycle request pulse towards the controller core. It then shows the matching busy flag until the core returns a completion pulse. A full reset is accepted only while the core reports that it is halted. Once started, the reset runs to its end even if software writes the bit back to 0. While it runs, the reset discards every other write and returns the enables and the save and restore flags to their defaults.

The same word also carries two enables. The interrupter enable gates the per-interrupter request lines onto the registered interrupt outputs. The system-error enable gates an error status input onto a registered out-of-band error output. A parameter decides whether light reset is built at all. When it is not built, the light reset bit always reads 0.

Top module: `hc_cmd_reg`

## Requirements
- R1: After the synchronous reset input `rst`, `rd_data` is 0 and every request, busy, interrupt and error output is 0.
- R2: A write with bit 8 set, made while no operation is busy, sets bit 8 of `rd_data` and `save_busy_o` from the next clock edge on. The same edge raises `save_req_o` for exactly one cycle. The flag clears on the edge that samples `save_done_i` high.
- R3: A write with bit 9 set (and bit 8 clear), made while no operation is busy, sets bit 9 of `rd_data` and `restore_busy_o` on the next edge. The same edge pulses `restore_req_o` for one cycle. The flag clears on the edge that samples `restore_done_i` high.
- R4: At most one save or restore is outstanding. A save or restore request written while either is busy is ignored. A write that sets both bits 8 and 9 starts only the save.
- R5: A write with bit 1 set while `halted_i` is 1 sets bit 1 of `rd_data` on the next edge and pulses `reset_req_o` for one cycle. Bit 1 stays 1, even through writes of 0, until the edge that samples `reset_done_i` high.
- R6: A write with bit 1 set while `halted_i` is 0 is ignored: bit 1 stays 0 and `reset_req_o` stays 0.
- R7: When a full reset is accepted, the same edge clears the save, restore and light busy flags and the enables in bits 2 and 3. Other fields of that write are discarded. While bit 1 reads 1, every write leaves `rd_data` unchanged.
- R8: `sys_err_o` equals, one edge later, the AND of the stored system-error enable (bit 3) and `hse_status_i`. It therefore stays high while both are 1.
- R9: Each bit of `intr_o` equals, one edge later, the matching bit of `intr_req_i` ANDed with the stored interrupter enable (bit 2). It is 0 whenever the enable is 0.
- R10: Bits 6:4 and all bits above 9 of `rd_data` always read 0. With `LIGHT_EN` = 0, bit 7 always reads 0 and `light_req_o` never rises.
- R11: With `LIGHT_EN` = 1, a write with bit 7 set, made outside a full reset, sets bit 7 on the next edge and pulses `light_req_o` for one cycle. Bit 7 holds 1 until the edge that samples `light_done_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Current register value |
| halted_i | input | 1 | Core reports halted (1) or running (0) |
| hse_status_i | input | 1 | System-error status bit, cleared by software elsewhere |
| intr_req_i | input | NUM_INTR | Interrupter interrupt requests |
| save_done_i | input | 1 | Core finished save |
| restore_done_i | input | 1 | Core finished restore |
| reset_done_i | input | 1 | Core finished full reset |
| light_done_i | input | 1 | Core finished light reset |
| save_req_o | output | 1 | One-cycle save request |
| restore_req_o | output | 1 | One-cycle restore request |
| reset_req_o | output | 1 | One-cycle full reset request |
| light_req_o | output | 1 | One-cycle light reset request |
| save_busy_o | output | 1 | Save in progress |
| restore_busy_o | output | 1 | Restore in progress |
| sys_err_o | output | 1 | Gated out-of-band system error |
| intr_o | output | NUM_INTR | Gated interrupt outputs |

## Verification
Two kinds of event can fall in one cycle. The first is a completion pulse and a new request write. The bench drives `reset_done_i` on the same edge as a fresh reset write. It expects bit 1 to fall and the new request to be dropped, because the block was still busy when it sampled the write. The second is a reset acceptance and a write of other fields. A single word carrying reset, save and both enables must leave only bit 1 set. A 1024-value sweep of the low ten write bits, with the core running, checks the save-over-restore priority and the zero reserved bits word by word, against values the bench computes from the written value.

// File: rtl/hc_cmd_pkg.sv
package hc_cmd_pkg;
  localparam int BIT_RST  = 1;
  localparam int BIT_INTE = 2;
  localparam int BIT_HSEE = 3;
  localparam int BIT_LRST = 7;
  localparam int BIT_SAVE = 8;
  localparam int BIT_RSTR = 9;
  localparam int MIN_W    = BIT_RSTR + 1;
endpackage

// File: rtl/hc_cmd_rst.sv
module hc_cmd_rst #(
  parameter bit LIGHT_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_rst,
  input  logic wr_light,
  input  logic halted_i,
  input  logic reset_done_i,
  input  logic light_done_i,
  output logic reset_busy,
  output logic reset_start,
  output logic reset_req_o,
  output logic light_busy,
  output logic light_req_o
);
  assign reset_start = wr_en && wr_rst && halted_i && !reset_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_busy  <= 1'b0;
      reset_req_o <= 1'b0;
    end else begin
      reset_req_o <= reset_start;
      if (reset_start)
        reset_busy <= 1'b1;
      else if (reset_done_i)
        reset_busy <= 1'b0;
    end
  end

  AST_RST_NOABORT: assert property (@(posedge clk) disable iff (rst)
    reset_busy && !reset_done_i |=> reset_busy); // R5
  AST_RST_INTERLOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_busy) |-> $past(halted_i)); // R6
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    reset_req_o |=> !reset_req_o); // R5

  generate
    if (LIGHT_EN) begin : g_light
      logic light_start;
      assign light_start = wr_en && wr_light && !reset_busy && !reset_start && !light_busy;
      always_ff @(posedge clk) begin
        if (rst || reset_start) begin
          light_busy  <= 1'b0;
          light_req_o <= 1'b0;
        end else begin
          light_req_o <= light_start;
          if (light_start)
            light_busy <= 1'b1;
          else if (light_done_i)
            light_busy <= 1'b0;
        end
      end
      AST_LRST_HOLD: assert property (@(posedge clk) disable iff (rst)
        light_busy && !light_done_i && !reset_start |=> light_busy); // R11
    end else begin : g_nolight
      logic unused_light;
      assign unused_light = wr_light ^ light_done_i;
      assign light_busy   = 1'b0;
      assign light_req_o  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/hc_cmd_ss.sv
module hc_cmd_ss (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_save,
  input  logic wr_rstr,
  input  logic block,
  input  logic flush,
  input  logic save_done_i,
  input  logic restore_done_i,
  output logic save_busy,
  output logic restore_busy,
  output logic save_req,
  output logic restore_req
);
  logic idle, save_start, restore_start;

  assign idle          = !save_busy && !restore_busy && !block && !flush;
  assign save_start    = wr_en && wr_save && idle;
  assign restore_start = wr_en && wr_rstr && !wr_save && idle;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      save_busy    <= 1'b0;
      restore_busy <= 1'b0;
      save_req     <= 1'b0;
      restore_req  <= 1'b0;
    end else begin
      save_req    <= save_start;
      restore_req <= restore_start;
      if (save_start)
        save_busy <= 1'b1;
      else if (save_done_i)
        save_busy <= 1'b0;
      if (restore_start)
        restore_busy <= 1'b1;
      else if (restore_done_i)
        restore_busy <= 1'b0;
    end
  end

  AST_SS_ONE: assert property (@(posedge clk) disable iff (rst)
    !(save_busy && restore_busy)); // R4
  AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    save_busy && !save_done_i && !flush |=> save_busy); // R2
  AST_RSTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    restore_busy && !restore_done_i && !flush |=> restore_busy); // R3
  AST_SAVE_PULSE: assert property (@(posedge clk) disable iff (rst)
    save_req |=> !save_req); // R2
endmodule

// File: rtl/hc_cmd_gate.sv
module hc_cmd_gate #(
  parameter int NUM_INTR = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_inte,
  input  logic                wr_hsee,
  input  logic                block,
  input  logic                flush,
  input  logic                hse_status_i,
  input  logic [NUM_INTR-1:0] intr_req_i,
  output logic                inte,
  output logic                hsee,
  output logic                sys_err_o,
  output logic [NUM_INTR-1:0] intr_o
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      inte <= 1'b0;
      hsee <= 1'b0;
    end else if (wr_en && !block) begin
      inte <= wr_inte;
      hsee <= wr_hsee;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sys_err_o <= 1'b0;
    else     sys_err_o <= hsee && hse_status_i;
  end

  generate
    for (genvar g = 0; g < NUM_INTR; g++) begin : g_intr
      always_ff @(posedge clk) begin
        if (rst) intr_o[g] <= 1'b0;
        else     intr_o[g] <= intr_req_i[g] && inte;
      end
    end
  endgenerate

  AST_SYSERR_GATE: assert property (@(posedge clk) disable iff (rst)
    sys_err_o |-> $past(hsee) && $past(hse_status_i)); // R8
  AST_INTR_GATE: assert property (@(posedge clk) disable iff (rst)
    (|intr_o) |-> $past(inte)); // R9
endmodule

// File: rtl/hc_cmd_reg.sv
module hc_cmd_reg
  import hc_cmd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_INTR = 2,
  parameter bit LIGHT_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                halted_i,
  input  logic                hse_status_i,
  input  logic [NUM_INTR-1:0] intr_req_i,
  input  logic                save_done_i,
  input  logic                restore_done_i,
  input  logic                reset_done_i,
  input  logic                light_done_i,
  output logic                save_req_o,
  output logic                restore_req_o,
  output logic                reset_req_o,
  output logic                light_req_o,
  output logic                save_busy_o,
  output logic                restore_busy_o,
  output logic                sys_err_o,
  output logic [NUM_INTR-1:0] intr_o
);
  localparam int PAD_W = DATA_W - MIN_W;

  logic reset_busy, reset_start, light_busy;
  logic save_busy, restore_busy, inte, hsee;
  logic unused_wr;

  assign unused_wr = ^wr_data;

  hc_cmd_rst #(.LIGHT_EN(LIGHT_EN)) rst_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_rst       (wr_data[BIT_RST]),
    .wr_light     (wr_data[BIT_LRST]),
    .halted_i     (halted_i),
    .reset_done_i (reset_done_i),
    .light_done_i (light_done_i),
    .reset_busy   (reset_busy),
    .reset_start  (reset_start),
    .reset_req_o  (reset_req_o),
    .light_busy   (light_busy),
    .light_req_o  (light_req_o)
  );

  hc_cmd_ss ss_i (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_save        (wr_data[BIT_SAVE]),
    .wr_rstr        (wr_data[BIT_RSTR]),
    .block          (reset_busy),
    .flush          (reset_start),
    .save_done_i    (save_done_i),
    .restore_done_i (restore_done_i),
    .save_busy      (save_busy),
    .restore_busy   (restore_busy),
    .save_req       (save_req_o),
    .restore_req    (restore_req_o)
  );

  hc_cmd_gate #(.NUM_INTR(NUM_INTR)) gate_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_inte      (wr_data[BIT_INTE]),
    .wr_hsee      (wr_data[BIT_HSEE]),
    .block        (reset_busy),
    .flush        (reset_start),
    .hse_status_i (hse_status_i),
    .intr_req_i   (intr_req_i),
    .inte         (inte),
    .hsee         (hsee),
    .sys_err_o    (sys_err_o),
    .intr_o       (intr_o)
  );

  assign save_busy_o    = save_busy;
  assign restore_busy_o = restore_busy;

  always_comb begin
    rd_data           = {{PAD_W{1'b0}}, {MIN_W{1'b0}}};
    rd_data[BIT_RST]  = reset_busy;
    rd_data[BIT_INTE] = inte;
    rd_data[BIT_HSEE] = hsee;
    rd_data[BIT_LRST] = light_busy;
    rd_data[BIT_SAVE] = save_busy;
    rd_data[BIT_RSTR] = restore_busy;
  end

  AST_DROP_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    reset_busy |=> $stable({inte, hsee, save_busy, restore_busy, light_busy})); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_busy) |-> !save_busy && !restore_busy && !inte && !hsee); // R7
endmodule

// File: tb/hc_cmd_reg_tb_top.sv
`timescale 1ns/1ps
module hc_cmd_reg_tb_top;
  localparam int DW = 32;
  localparam int NI = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic halted = 1'b0, hse = 1'b0;
  logic [NI-1:0] ireq = '0;
  logic sdone = 1'b0, rdone = 1'b0, xdone = 1'b0, ldone = 1'b0;

  logic [DW-1:0] rd, rd_nl;
  logic sreq, rreq, xreq, lreq, sbusy, rbusy, serr;
  logic [NI-1:0] intr;
  logic sreq_nl, rreq_nl, xreq_nl, lreq_nl, sbusy_nl, rbusy_nl, serr_nl;
  logic [NI-1:0] intr_nl;

  int vecs = 0;
  int bad  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hc_cmd_reg #(.DATA_W(DW), .NUM_INTR(NI), .LIGHT_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd),
    .halted_i(halted), .hse_status_i(hse), .intr_req_i(ireq),
    .save_done_i(sdone), .restore_done_i(rdone), .reset_done_i(xdone),
    .light_done_i(ldone), .save_req_o(sreq), .restore_req_o(rreq),
    .reset_req_o(xreq), .light_req_o(lreq), .save_busy_o(sbusy),
    .restore_busy_o(rbusy), .sys_err_o(serr), .intr_o(intr));

  hc_cmd_reg #(.DATA_W(DW), .NUM_INTR(NI), .LIGHT_EN(1'b0)) dut_nl_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_nl),
    .halted_i(halted), .hse_status_i(hse), .intr_req_i(ireq),
    .save_done_i(sdone), .restore_done_i(rdone), .reset_done_i(xdone),
    .light_done_i(ldone), .save_req_o(sreq_nl), .restore_req_o(rreq_nl),
    .reset_req_o(xreq_nl), .light_req_o(lreq_nl), .save_busy_o(sbusy_nl),
    .restore_busy_o(rbusy_nl), .sys_err_o(serr_nl), .intr_o(intr_nl));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [DW-1:0] v);
    wr_en = 1'b1;
    wr_data = v;
    tick();
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic done_all();
    sdone = 1'b1; rdone = 1'b1; ldone = 1'b1;
    tick();
    sdone = 1'b0; rdone = 1'b0; ldone = 1'b0;
  endtask

  function automatic logic [DW-1:0] exp_word(input logic [DW-1:0] v, input bit light);
    logic [DW-1:0] e;
    e = '0;
    e[8] = v[8];
    e[9] = v[9] & ~v[8];
    e[7] = v[7] & light;
    e[2] = v[2];
    e[3] = v[3];
    return e;
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++;
      vecs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 rd", rd, '0);
    chk("R1 outs", {28'd0, sreq, rreq, xreq, lreq, sbusy, rbusy, serr, intr, 1'b0}, '0);
    chk("R1 rd_nl", rd_nl, '0);

    // R2 save handshake
    wr(32'h100);
    chk("R2 req", {31'd0, sreq}, 32'd1);
    chk("R2 busy", {30'd0, sbusy, rd[8]}, 32'd3);
    tick();
    chk("R2 pulse ends", {31'd0, sreq}, 32'd0);
    chk("R2 holds", {31'd0, sbusy}, 32'd1);
    // R4 restore while save busy is ignored
    wr(32'h200);
    chk("R4 ignored", {31'd0, rbusy}, 32'd0);
    chk("R4 no req", {31'd0, rreq}, 32'd0);
    sdone = 1'b1; tick(); sdone = 1'b0;
    chk("R2 cleared", rd, '0);

    // R3 restore handshake
    wr(32'h200);
    chk("R3 req", {31'd0, rreq}, 32'd1);
    chk("R3 busy", {30'd0, rbusy, rd[9]}, 32'd3);
    wr(32'h100);
    chk("R4 save during restore", {31'd0, sbusy}, 32'd0);
    rdone = 1'b1; tick(); rdone = 1'b0;
    chk("R3 cleared", rd, '0);

    // R6 interlock with running core
    halted = 1'b0;
    wr(32'h002);
    chk("R6 rd", rd, '0);
    chk("R6 req", {31'd0, xreq}, 32'd0);

    // R5 / R7 reset sequence
    halted = 1'b1;
    wr(32'h10C);
    chk("R7 setup", rd, 32'h10C);
    wr(32'h30E);
    chk("R7 flush", rd, 32'h002);
    chk("R5 req", {31'd0, xreq}, 32'd1);
    wr(32'h000);
    chk("R5 no abort", rd, 32'h002);
    chk("R5 pulse ends", {31'd0, xreq}, 32'd0);
    wr(32'h38C);
    chk("R7 dropped", rd, 32'h002);
    // completion coinciding with a fresh reset write
    xdone = 1'b1;
    wr_en = 1'b1; wr_data = 32'h002;
    tick();
    xdone = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R5 done same cycle", rd, '0);
    chk("R5 no new req", {31'd0, xreq}, 32'd0);

    // R11 light reset, R10 without light
    halted = 1'b0;
    wr(32'h080);
    chk("R11 req", {31'd0, lreq}, 32'd1);
    chk("R11 busy", rd, 32'h080);
    chk("R10 nl bit7", rd_nl, '0);
    chk("R10 nl req", {31'd0, lreq_nl}, 32'd0);
    tick();
    chk("R11 holds", rd, 32'h080);
    ldone = 1'b1; tick(); ldone = 1'b0;
    chk("R11 cleared", rd, '0);

    // R8 / R9 gating sweep
    for (int c = 0; c < 32; c++) begin
      logic he, ie, hs;
      logic [NI-1:0] iq;
      he = c[0]; ie = c[1]; hs = c[2]; iq = c[4:3];
      hse = hs; ireq = iq;
      wr({28'd0, he, ie, 2'b00});
      tick();
      chk("R8 sys_err", {31'd0, serr}, {31'd0, he & hs});
      chk("R9 intr", {30'd0, intr}, {30'd0, iq & {NI{ie}}});
    end
    hse = 1'b0; ireq = '0;
    wr('0);

    // R4 / R10 / R2 / R3 / R11 write sweep with core running
    for (int v = 0; v < 1024; v++) begin
      logic [DW-1:0] w, e;
      w = v;
      wr(w);
      e = exp_word(w, 1'b1);
      chk("R10 R4 sweep", rd, e);
      chk("R10 sweep nl", rd_nl, exp_word(w, 1'b0));
      chk("R2 R3 R11 pulses", {29'd0, sreq, rreq, lreq}, {29'd0, e[8], e[9], e[7]});
      done_all();
      chk("R2 R3 R11 sweep clear", rd, e & 32'h00C);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule